// File: doc/BRIEF.md
# Receive Frame Filter with Statistics

This block sits behind the receive path of an Ethernet MAC. It takes a byte stream with start-of-frame and end-of-frame markers, plus a set of per-frame flags presented with the end-of-frame beat: bad CRC, upstream truncation, address match, pause frame, broadcast and multicast. At the end of every frame it decides whether the frame is kept or dropped. It forwards the stream one cycle later, optionally with the four FCS bytes removed, and marks dropped frames on their last output beat so that downstream logic can discard them.

Eight saturating statistics counters are updated once per frame at its end. A pulse is raised for every accepted frame and for every counter that reaches its ceiling. Address comparison and whole-frame buffering are done elsewhere. All configuration arrives on static inputs.

Top module: `rx_frame_filter`

## Requirements
- R1: A frame starts only on a beat with `in_valid` and `in_sof` high while `cfg_enable` is high and no frame is in progress. Beats outside a started frame produce no output beat.
- R2: Clearing `cfg_enable` after a frame has started does not cut that frame. Every output beat of it is still produced, including the beat that carries `out_eof`.
- R3: A frame whose `in_crc_err` or `in_trunc` is high at its end is dropped, unless `cfg_crc_chk_off` is high.
- R4: A frame with `in_addr_match` low is dropped when the matching promiscuous bit is low. Frames flagged broadcast or multicast use `cfg_promisc_grp`; all other frames use `cfg_promisc_uni`.
- R5: A frame with `in_is_pause` high is dropped unless `cfg_pass_pause` is high.
- R6: A frame of N total bytes has a payload of N-18 (14 header bytes and 4 FCS bytes removed). It is dropped unless 64 <= N-18 <= `cfg_max_len`.
- R7: When `cfg_strip_fcs` is high at the frame's start beat, the last 4 bytes are not forwarded: an N-byte frame (N > 4) yields its first N-4 bytes, and `out_eof` sits on the last of them. Otherwise all N bytes are forwarded. Each output beat follows its input beat by one cycle.
- R8: `out_drop` is high only on the `out_eof` beat of a dropped frame. `ev_frame_ok` pulses for one cycle, one cycle after the end beat of each accepted frame.
- R9: `stat_cnt` index 0 counts accepted frames, 1 the bytes of all ended frames, 2 dropped frames, 3 the bytes of dropped frames, 4 frames with CRC error or truncation, 5 pause frames, 6 broadcast frames and 7 multicast frames. Each updates one cycle after the frame's end beat.
- R10: Each counter saturates at all-ones and stays there. `ev_sat[i]` pulses once, in the cycle in which counter i first reaches all-ones.
- R11: If `cfg_enable` is low on a frame's end beat, no counter changes and `ev_frame_ok` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | DATA_W | Input byte |
| in_crc_err | input | 1 | Frame has bad CRC (sampled at end beat) |
| in_trunc | input | 1 | Frame was truncated upstream (end beat) |
| in_addr_match | input | 1 | Destination address matched (end beat) |
| in_is_pause | input | 1 | Frame is a pause frame (end beat) |
| in_is_bcast | input | 1 | Frame is broadcast (end beat) |
| in_is_mcast | input | 1 | Frame is multicast (end beat) |
| cfg_enable | input | 1 | Receive enable |
| cfg_crc_chk_off | input | 1 | Keep frames with CRC errors |
| cfg_strip_fcs | input | 1 | Remove the FCS bytes from the output |
| cfg_pass_pause | input | 1 | Keep pause frames |
| cfg_promisc_uni | input | 1 | Accept unicast frames without address match |
| cfg_promisc_grp | input | 1 | Accept group frames without address match |
| cfg_max_len | input | MAXLEN_W | Largest accepted payload length |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_drop | output | 1 | Frame is dropped (on the last beat) |
| out_data | output | DATA_W | Output byte |
| ev_frame_ok | output | 1 | Accepted-frame pulse |
| ev_sat | output | 8 | Per-counter saturation pulse |
| stat_cnt | output | 8 x CNT_W | Statistics counters |

## Verification
An output beat is due one cycle after its input beat. Counter values, `ev_frame_ok` and `ev_sat` are due one cycle after the end-of-frame beat. The bench drives inputs and samples outputs on the falling clock edge. It collects output beats and event pulses continuously, then waits two full cycles after the end beat before comparing the collected stream and all eight counters with its own model. Saturation is checked by counting `ev_sat` pulses per counter against the number of times the model first reaches the ceiling, using a narrow counter width on the bench instance.

// File: rtl/rff_pkg.sv
package rff_pkg;

    localparam int NUM_CNT = 8;

    // statistics counter slots
    localparam int CI_OK_FRM   = 0;
    localparam int CI_ALL_BYTE = 1;
    localparam int CI_DRP_FRM  = 2;
    localparam int CI_DRP_BYTE = 3;
    localparam int CI_CRC      = 4;
    localparam int CI_PAUSE    = 5;
    localparam int CI_BCAST    = 6;
    localparam int CI_MCAST    = 7;

    typedef struct packed {
        logic crc_err;
        logic trunc;
        logic addr_match;
        logic is_pause;
        logic is_bcast;
        logic is_mcast;
    } frame_flags_t;

    typedef struct packed {
        logic enable;
        logic crc_chk_off;
        logic strip_fcs;
        logic pass_pause;
        logic promisc_uni;
        logic promisc_grp;
    } rx_cfg_t;

    typedef struct packed {
        logic drop;
        logic crc_evt;
    } verdict_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rff_sat_counter.sv
module rff_sat_counter #(
    parameter int CNT_W = 32,
    parameter int AMT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [AMT_W-1:0] inc_amt,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    import rff_pkg::*;

    localparam int SUM_W = max_int(CNT_W, AMT_W) + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'({CNT_W{1'b1}});

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        sum = SUM_W'(cnt) + SUM_W'(inc_amt);
        nxt = (sum >= TOP) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            hit <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (inc_en) begin
                cnt <= nxt;
                hit <= (cnt != {CNT_W{1'b1}}) && (nxt == {CNT_W{1'b1}});
            end
        end
    end

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}})); // R10
    AST_HIT_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        hit |-> (cnt == {CNT_W{1'b1}})); // R10
    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !inc_en |=> $stable(cnt)); // R11

endmodule

// File: rtl/rff_drop_decide.sv
module rff_drop_decide #(
    parameter int LEN_W       = 16,
    parameter int MAXLEN_W    = 14,
    parameter int HDR_BYTES   = 14,
    parameter int FCS_BYTES   = 4,
    parameter int MIN_PAYLOAD = 64
) (
    input  rff_pkg::frame_flags_t flags,
    input  rff_pkg::rx_cfg_t      cfg,
    input  logic [MAXLEN_W-1:0]   max_len,
    input  logic [LEN_W-1:0]      tot_len,
    output rff_pkg::verdict_t     verdict
);
    localparam int OVH       = HDR_BYTES + FCS_BYTES;
    localparam int MIN_TOTAL = OVH + MIN_PAYLOAD;

    logic crc_drop, addr_drop, pause_drop, len_ok, group;

    always_comb begin
        group      = flags.is_bcast | flags.is_mcast;
        crc_drop   = (flags.crc_err | flags.trunc) & ~cfg.crc_chk_off;
        addr_drop  = ~flags.addr_match & (group ? ~cfg.promisc_grp : ~cfg.promisc_uni);
        pause_drop = flags.is_pause & ~cfg.pass_pause;
        len_ok     = ((LEN_W+1)'(tot_len) >= (LEN_W+1)'(MIN_TOTAL)) &&
                     ((LEN_W+1)'(tot_len) <= (LEN_W+1)'(max_len) + (LEN_W+1)'(OVH));
        verdict.drop    = crc_drop | addr_drop | pause_drop | ~len_ok;
        verdict.crc_evt = flags.crc_err | flags.trunc;
    end

endmodule

// File: rtl/rff_frame_track.sv
module rff_frame_track #(
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 16,
    parameter int FCS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic              enable,
    input  logic              strip_cfg,
    input  logic              drop_now,
    output logic              last_beat,
    output logic [LEN_W-1:0]  frame_len,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_drop,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [LEN_W-1:0] FCS_L = LEN_W'(FCS_BYTES);

    logic                             active, strip_q, emitted;
    logic [LEN_W-1:0]                 byte_cnt;
    logic [FCS_BYTES-1:0][DATA_W-1:0] dly;
    logic                             start, beat, strip_now, tail_ok, emit;

    always_comb begin
        start     = in_valid & in_sof & ~active & enable;
        beat      = in_valid & (active | start);
        frame_len = start ? LEN_W'(1) :
                    ((byte_cnt == {LEN_W{1'b1}}) ? byte_cnt : byte_cnt + LEN_W'(1));
        strip_now = start ? strip_cfg : strip_q;
        tail_ok   = frame_len > FCS_L;
        emit      = beat & (~strip_now | tail_ok | in_eof);
        last_beat = beat & in_eof;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            strip_q   <= 1'b0;
            emitted   <= 1'b0;
            byte_cnt  <= '0;
            dly       <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_drop  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit & (start | ~emitted);
            out_eof   <= last_beat;
            out_drop  <= last_beat & drop_now;
            out_data  <= ~strip_now ? in_data :
                         (tail_ok ? dly[FCS_BYTES-1] : '0);
            if (beat) begin
                byte_cnt <= frame_len;
                dly[0]   <= in_data;
                for (int i = 1; i < FCS_BYTES; i++) dly[i] <= dly[i-1];
            end
            if (start) begin
                strip_q <= strip_cfg;
                emitted <= emit;
                active  <= ~in_eof;
            end else if (beat) begin
                emitted <= emitted | emit;
                if (in_eof) active <= 1'b0;
            end
        end
    end

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !active && !(in_sof && enable)) |=> !out_valid); // R1
    AST_EOF_IS_BEAT: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_valid); // R2

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 32,
    parameter int LEN_W       = 16,
    parameter int MAXLEN_W    = 14,
    parameter int HDR_BYTES   = 14,
    parameter int FCS_BYTES   = 4,
    parameter int MIN_PAYLOAD = 64
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    input  logic                                   in_sof,
    input  logic                                   in_eof,
    input  logic [DATA_W-1:0]                      in_data,
    input  logic                                   in_crc_err,
    input  logic                                   in_trunc,
    input  logic                                   in_addr_match,
    input  logic                                   in_is_pause,
    input  logic                                   in_is_bcast,
    input  logic                                   in_is_mcast,
    input  logic                                   cfg_enable,
    input  logic                                   cfg_crc_chk_off,
    input  logic                                   cfg_strip_fcs,
    input  logic                                   cfg_pass_pause,
    input  logic                                   cfg_promisc_uni,
    input  logic                                   cfg_promisc_grp,
    input  logic [MAXLEN_W-1:0]                    cfg_max_len,
    output logic                                   out_valid,
    output logic                                   out_sof,
    output logic                                   out_eof,
    output logic                                   out_drop,
    output logic [DATA_W-1:0]                      out_data,
    output logic                                   ev_frame_ok,
    output logic [rff_pkg::NUM_CNT-1:0]            ev_sat,
    output logic [rff_pkg::NUM_CNT-1:0][CNT_W-1:0] stat_cnt
);
    import rff_pkg::*;

    frame_flags_t                    flags;
    rx_cfg_t                         cfg;
    verdict_t                        verdict;
    logic                            last_beat, upd;
    logic [LEN_W-1:0]                frame_len;
    logic [NUM_CNT-1:0]              cnt_inc;
    logic [NUM_CNT-1:0][LEN_W-1:0]   cnt_amt;

    always_comb begin
        flags = '{crc_err: in_crc_err, trunc: in_trunc, addr_match: in_addr_match,
                  is_pause: in_is_pause, is_bcast: in_is_bcast, is_mcast: in_is_mcast};
        cfg   = '{enable: cfg_enable, crc_chk_off: cfg_crc_chk_off,
                  strip_fcs: cfg_strip_fcs, pass_pause: cfg_pass_pause,
                  promisc_uni: cfg_promisc_uni, promisc_grp: cfg_promisc_grp};
    end

    rff_frame_track #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FCS_BYTES(FCS_BYTES)) u_track (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .enable(cfg.enable), .strip_cfg(cfg.strip_fcs), .drop_now(verdict.drop),
        .last_beat(last_beat), .frame_len(frame_len),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_drop(out_drop), .out_data(out_data)
    );

    rff_drop_decide #(.LEN_W(LEN_W), .MAXLEN_W(MAXLEN_W), .HDR_BYTES(HDR_BYTES),
                      .FCS_BYTES(FCS_BYTES), .MIN_PAYLOAD(MIN_PAYLOAD)) u_decide (
        .flags(flags), .cfg(cfg), .max_len(cfg_max_len),
        .tot_len(frame_len), .verdict(verdict)
    );

    always_comb begin
        upd                  = last_beat & cfg.enable;
        cnt_amt              = '{default: LEN_W'(1)};
        cnt_amt[CI_ALL_BYTE] = frame_len;
        cnt_amt[CI_DRP_BYTE] = frame_len;
        cnt_inc[CI_OK_FRM]   = upd & ~verdict.drop;
        cnt_inc[CI_ALL_BYTE] = upd;
        cnt_inc[CI_DRP_FRM]  = upd & verdict.drop;
        cnt_inc[CI_DRP_BYTE] = upd & verdict.drop;
        cnt_inc[CI_CRC]      = upd & verdict.crc_evt;
        cnt_inc[CI_PAUSE]    = upd & flags.is_pause;
        cnt_inc[CI_BCAST]    = upd & flags.is_bcast;
        cnt_inc[CI_MCAST]    = upd & flags.is_mcast;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rff_sat_counter #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_cnt (
            .clk(clk), .rst(rst), .inc_en(cnt_inc[g]), .inc_amt(cnt_amt[g]),
            .cnt(stat_cnt[g]), .hit(ev_sat[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) ev_frame_ok <= 1'b0;
        else     ev_frame_ok <= upd & ~verdict.drop;
    end

    AST_DROP_ON_EOF: assert property (@(posedge clk) disable iff (rst)
        out_drop |-> (out_eof && out_valid)); // R8
    AST_OK_NOT_DROPPED: assert property (@(posedge clk) disable iff (rst)
        ev_frame_ok |-> (out_eof && !out_drop)); // R8
    AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !ev_frame_ok); // R11

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;
    localparam int CW   = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_data = '0;
    logic in_crc_err = 0, in_trunc = 0, in_addr_match = 1, in_is_pause = 0;
    logic in_is_bcast = 0, in_is_mcast = 0;
    logic cfg_enable = 1, cfg_crc_chk_off = 0, cfg_strip_fcs = 0, cfg_pass_pause = 0;
    logic cfg_promisc_uni = 0, cfg_promisc_grp = 0;
    logic [13:0] cfg_max_len = 14'd1500;
    logic out_valid, out_sof, out_eof, out_drop, ev_frame_ok;
    logic [7:0] out_data;
    logic [7:0] ev_sat;
    logic [7:0][CW-1:0] stat_cnt;

    always #5 clk = ~clk;

    rx_frame_filter #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .in_crc_err(in_crc_err), .in_trunc(in_trunc),
        .in_addr_match(in_addr_match), .in_is_pause(in_is_pause),
        .in_is_bcast(in_is_bcast), .in_is_mcast(in_is_mcast),
        .cfg_enable(cfg_enable), .cfg_crc_chk_off(cfg_crc_chk_off),
        .cfg_strip_fcs(cfg_strip_fcs), .cfg_pass_pause(cfg_pass_pause),
        .cfg_promisc_uni(cfg_promisc_uni), .cfg_promisc_grp(cfg_promisc_grp),
        .cfg_max_len(cfg_max_len), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_drop(out_drop), .out_data(out_data),
        .ev_frame_ok(ev_frame_ok), .ev_sat(ev_sat), .stat_cnt(stat_cnt)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] cap[$];
    int n_sof = 0, n_eof = 0, n_ok = 0;
    bit last_drop = 0;
    int n_sat[8];
    int exp_cnt[8];
    int exp_hits[8];
    int exp_ok = 0;

    initial begin
        for (int i = 0; i < 8; i++) begin n_sat[i] = 0; exp_cnt[i] = 0; exp_hits[i] = 0; end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                cap.push_back(out_data);
                if (out_sof) n_sof++;
                if (out_eof) begin n_eof++; last_drop = out_drop; end
            end
            if (ev_frame_ok) n_ok++;
            for (int i = 0; i < 8; i++) if (ev_sat[i]) n_sat[i]++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_add(input int idx, input int amt);
        int old = exp_cnt[idx];
        int nv  = old + amt;
        if (nv > MAXC) nv = MAXC;
        if (old != MAXC && nv == MAXC) exp_hits[idx]++;
        exp_cnt[idx] = nv;
    endtask

    task automatic check_counters(input string req);
        for (int i = 0; i < 8; i++)
            chk(int'(stat_cnt[i]) == exp_cnt[i], req, $sformatf("stat_cnt[%0d]", i),
                stat_cnt[i], exp_cnt[i]);
        chk(n_ok == exp_ok, req, "ev_frame_ok count", n_ok, exp_ok);
    endtask

    // Drives one frame; flags held for the whole frame. mid_off clears enable mid-frame.
    task automatic send(input int len, input bit crc, input bit tr, input bit am,
                        input bit ps, input bit bc, input bit mc, input bit mid_off,
                        input int seed, input string req, input bit full_check);
        bit started, en_end, strip, grp, drop;
        int pay, exp_n;
        cap.delete(); n_sof = 0; n_eof = 0;
        started = cfg_enable;
        strip   = cfg_strip_fcs;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (k == 0); in_eof = (k == len - 1);
            in_data = 8'(k * 7 + seed);
            in_crc_err = crc; in_trunc = tr; in_addr_match = am;
            in_is_pause = ps; in_is_bcast = bc; in_is_mcast = mc;
            if (mid_off && k == len / 2) cfg_enable = 0;
        end
        en_end = cfg_enable;
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (2) @(negedge clk);
        grp  = bc | mc;
        pay  = len - 18;
        drop = ((crc | tr) && !cfg_crc_chk_off) ||
               (!am && (grp ? !cfg_promisc_grp : !cfg_promisc_uni)) ||
               (ps && !cfg_pass_pause) || (pay < 64) || (pay > int'(cfg_max_len));
        if (!started) begin
            chk(cap.size() == 0, req, "output beats for unstarted frame", cap.size(), 0);
        end else begin
            exp_n = strip ? ((len > 4) ? len - 4 : 1) : len;
            if (full_check) begin
                chk(cap.size() == exp_n, req, "output beat count", cap.size(), exp_n);
                chk(n_sof == 1 && n_eof == 1, req, "sof/eof count", n_sof * 10 + n_eof, 11);
                if (cap.size() == exp_n && len > 4)
                    for (int k = 0; k < exp_n; k++)
                        if (cap[k] != 8'(k * 7 + seed))
                            chk(0, req, $sformatf("byte %0d", k), cap[k], 8'(k * 7 + seed));
            end
            chk(last_drop == drop, req, "out_drop on eof", last_drop, drop);
            if (en_end) begin
                if (!drop) begin model_add(0, 1); exp_ok++; end
                model_add(1, len);
                if (drop) begin model_add(2, 1); model_add(3, len); end
                if (crc | tr) model_add(4, 1);
                if (ps) model_add(5, 1);
                if (bc) model_add(6, 1);
                if (mc) model_add(7, 1);
            end
        end
        if (full_check) check_counters("R9");
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R9", "out_valid after reset", out_valid, 0);
        check_counters("R9");
    endtask

    task automatic t_basic();
        send(82, 0, 0, 1, 0, 0, 0, 0, 3, "R6", 1);     // payload 64 accepted
        send(81, 0, 0, 1, 0, 0, 0, 0, 5, "R6", 1);     // payload 63 dropped
        cfg_max_len = 14'd100;
        send(118, 0, 0, 1, 0, 0, 0, 0, 9, "R6", 1);    // payload 100 accepted
        send(119, 0, 0, 1, 0, 0, 0, 0, 11, "R6", 1);   // payload 101 dropped
        cfg_max_len = 14'd1500;
    endtask

    task automatic t_strip();
        cfg_strip_fcs = 1;
        send(100, 0, 0, 1, 0, 0, 0, 0, 17, "R7", 1);
        send(90, 1, 0, 1, 0, 0, 0, 0, 19, "R7", 1);
        cfg_strip_fcs = 0;
    endtask

    task automatic t_crc();
        send(90, 1, 0, 1, 0, 0, 0, 0, 21, "R3", 1);
        send(90, 0, 1, 1, 0, 0, 0, 0, 23, "R3", 1);
        cfg_crc_chk_off = 1;
        send(90, 1, 0, 1, 0, 0, 0, 0, 25, "R3", 1);
        cfg_crc_chk_off = 0;
    endtask

    task automatic t_addr();
        send(90, 0, 0, 0, 0, 0, 0, 0, 27, "R4", 1);
        cfg_promisc_uni = 1;
        send(90, 0, 0, 0, 0, 0, 0, 0, 29, "R4", 1);
        send(90, 0, 0, 0, 0, 0, 1, 0, 31, "R4", 1);    // group still dropped
        cfg_promisc_grp = 1; cfg_promisc_uni = 0;
        send(90, 0, 0, 0, 0, 1, 0, 0, 33, "R4", 1);
        send(90, 0, 0, 0, 0, 0, 0, 0, 35, "R4", 1);    // unicast dropped again
        cfg_promisc_grp = 0;
    endtask

    task automatic t_pause();
        send(90, 0, 0, 1, 1, 0, 1, 0, 37, "R5", 1);
        cfg_pass_pause = 1;
        send(90, 0, 0, 1, 1, 0, 1, 0, 39, "R5", 1);
        cfg_pass_pause = 0;
    endtask

    task automatic t_gating();
        cap.delete();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); in_valid = 1; in_sof = 0; in_eof = (k == 4); in_data = 8'(k);
        end
        @(negedge clk); in_valid = 0; in_eof = 0;
        repeat (2) @(negedge clk);
        chk(cap.size() == 0, "R1", "beats without sof", cap.size(), 0);
        cfg_enable = 0;
        send(90, 0, 0, 1, 0, 0, 0, 0, 41, "R1", 1);
        cfg_enable = 1;
    endtask

    task automatic t_mid_off();
        int ok_before = n_ok;
        send(90, 0, 0, 1, 0, 1, 0, 1, 43, "R2", 1);
        chk(n_ok == ok_before, "R11", "ev_frame_ok while disabled", n_ok, ok_before);
        check_counters("R11");
        cfg_enable = 1;
    endtask

    task automatic t_saturate();
        for (int f = 0; f < 260; f++) send(1, 0, 0, 1, 0, 0, 1, 0, f, "R10", 0);
        for (int f = 0; f < 260; f++) send(82, 0, 0, 1, 0, 1, 0, 0, f, "R10", 0);
        check_counters("R10");
        for (int i = 0; i < 8; i++)
            chk(n_sat[i] == exp_hits[i], "R10", $sformatf("ev_sat[%0d] pulses", i),
                n_sat[i], exp_hits[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_strip();
        t_crc();
        t_addr();
        t_pause();
        t_gating();
        t_mid_off();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule